// File: doc/BRIEF.md
# SDRAM Bank Timing Guard

This block stands between a command scheduler and the SDRAM command pins. The scheduler offers one command per cycle: row open, read, write, single-bank close, close-all, or auto refresh. The block keeps, for each of four banks, whether a row is open and which row it is. A set of small down-counters remembers how long ago each timing-relevant command was issued. From that state it raises `in_ready` only when the offered command breaks no spacing rule, counted in clocks.

An accepted command leaves on the output pins one cycle later, unchanged. In every other cycle a NOP is driven. Some commands make no sense in the current bank state, such as a column access or close to a closed bank, an open to a bank that is already open, a refresh while any bank is open, or the reserved code. These are never forwarded. They raise `out_err` in the following cycle.

Back-pressure rules are as follows. A command transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is a combinational function of the offered command and bank, and it does not depend on `in_valid`. The block keeps no queue, so the scheduler may replace a command that was not accepted with a different one in the next cycle. A rejected command is not consumed and not remembered.

Top module: `sdram_cmd_guard`

## Requirements
- R1: During and right after reset, `out_cmd` is NOP (0), `out_err` is 0 and `bank_open` is 0.
- R2: The command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, PREA=5, REF=6, and 7 is reserved. A command offered with `in_valid` high and `in_ready` high appears on `out_cmd`/`out_bank`/`out_addr` in the next cycle. Otherwise the next cycle shows NOP with bank and address 0. A NOP offer is always ready.
- R3: RD or WR to a bank is ready only if the bank is open and at least T_RCD (default 2) clocks have passed since its ACT.
- R4: PRE to a bank is ready only if the bank is open, at least T_RAS (default 6) clocks have passed since its ACT, and at least T_WRP (default 2) clocks have passed since its last WR.
- R5: ACT commands to any banks are spaced at least T_RRD (default 2) clocks apart.
- R6: ACT to a bank needs the bank closed and at least T_RC (default 10) clocks since that bank's previous ACT.
- R7: ACT to a bank needs at least T_RP (default 2) clocks since the bank was closed, and at least T_DAL (default 5) clocks since its last WR.
- R8: Column commands have no spacing between them: RD/WR may be accepted on consecutive clocks.
- R9: RD, WR or PRE to a closed bank, ACT to an open bank, REF while any bank is open, and code 7 are never ready. When offered with `in_valid`, each of these gives `out_err`=1 with NOP on `out_cmd` in the next cycle.
- R10: REF is ready only when all banks are closed, each bank meets its T_RP and T_DAL spacing, and at least T_RC clocks have passed since the previous REF. ACT also waits T_RC clocks after a REF.
- R11: PREA is ready when every open bank meets its PRE spacing. It closes all open banks and restarts T_RP only for the banks it closed.
- R12: `bank_open[b]` shows whether bank b has an open row. While the offered bank is open, `cur_row` gives the row that its ACT carried on `in_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Offered command is valid |
| in_ready | output | 1 | Offered command is legal this cycle |
| in_cmd | input | 3 | Offered command code |
| in_bank | input | 2 | Offered bank |
| in_addr | input | 12 | Row for ACT, column/address for others |
| out_cmd | output | 3 | Command driven to the pins |
| out_bank | output | 2 | Bank driven to the pins |
| out_addr | output | 12 | Address driven to the pins |
| out_err | output | 1 | Previous-cycle offer was illegal for the bank state |
| bank_open | output | 4 | Per-bank open flags |
| cur_row | output | 12 | Open row of the offered bank |

## Verification
A directed opening sequence places commands exactly one clock inside and one clock outside each spacing window. This separates the read-after-open gap, the close-after-open and close-after-write gaps, the cross-bank open gap and the combined write-to-reopen gap from one another. Seeded random traffic then mixes all eight codes over random banks with occasional idle cycles. This reaches close-all over partly open bank sets, refresh attempts with recent writes, back-to-back column commands and state-illegal offers. Every cycle's ready, forwarded command, error flag, open mask and open row are compared with a timestamp model in the bench.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6,
    CMD_RSV  = 3'd7
  } cmd_e;
endpackage

// File: rtl/sdram_gap_timer.sv
// Down-counter: idle goes high GAP clocks after start was seen.
module sdram_gap_timer #(
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle
);
  localparam int W = $clog2(GAP + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= W'(GAP - 1);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/sdram_bank_track.sv
// State and spacing timers of one bank.
module sdram_bank_track #(
  parameter int ROW_W = 12,
  parameter int T_RCD = 2,
  parameter int T_RAS = 6,
  parameter int T_RC  = 10,
  parameter int T_RP  = 2,
  parameter int T_WRP = 2,
  parameter int T_DAL = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_wr,
  input  logic             do_close,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             col_ok,
  output logic             pre_ok,
  output logic             rest_ok,
  output logic             act_ok
);
  logic rcd_idle, ras_idle, rc_idle, rp_idle, wrp_idle, dal_idle;

  sdram_gap_timer #(.GAP(T_RCD)) u_rcd (.clk(clk), .rst_n(rst_n), .start(do_act),   .idle(rcd_idle));
  sdram_gap_timer #(.GAP(T_RAS)) u_ras (.clk(clk), .rst_n(rst_n), .start(do_act),   .idle(ras_idle));
  sdram_gap_timer #(.GAP(T_RC))  u_rc  (.clk(clk), .rst_n(rst_n), .start(do_act),   .idle(rc_idle));
  sdram_gap_timer #(.GAP(T_RP))  u_rp  (.clk(clk), .rst_n(rst_n), .start(do_close), .idle(rp_idle));
  sdram_gap_timer #(.GAP(T_WRP)) u_wrp (.clk(clk), .rst_n(rst_n), .start(do_wr),    .idle(wrp_idle));
  sdram_gap_timer #(.GAP(T_DAL)) u_dal (.clk(clk), .rst_n(rst_n), .start(do_wr),    .idle(dal_idle));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
    end else if (do_act) begin
      is_open  <= 1'b1;
      open_row <= row_in;
    end else if (do_close) begin
      is_open  <= 1'b0;
    end
  end

  assign col_ok  = is_open & rcd_idle;
  assign pre_ok  = is_open & ras_idle & wrp_idle;
  assign rest_ok = ~is_open & rp_idle & dal_idle;
  assign act_ok  = rest_ok & rc_idle;
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 10,
  parameter int T_RP      = 2,
  parameter int T_RRD     = 2,
  parameter int T_WRP     = 2,
  parameter int T_DAL     = 5,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_cmd,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_addr,
  output logic [2:0]        out_cmd,
  output logic [BANK_W-1:0] out_bank,
  output logic [ROW_W-1:0]  out_addr,
  output logic              out_err,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [ROW_W-1:0]  cur_row
);
  cmd_e cmd;
  logic legal, bad, fire;
  logic rrd_idle, ref_idle;
  logic [NUM_BANKS-1:0] col_ok, pre_ok, rest_ok, act_ok;
  logic [ROW_W-1:0] rows [NUM_BANKS];

  assign cmd  = cmd_e'(in_cmd);
  assign fire = in_valid & legal;

  sdram_gap_timer #(.GAP(T_RRD)) u_rrd (
    .clk(clk), .rst_n(rst_n), .start(fire && cmd == CMD_ACT), .idle(rrd_idle));
  sdram_gap_timer #(.GAP(T_RC)) u_refg (
    .clk(clk), .rst_n(rst_n), .start(fire && cmd == CMD_REF), .idle(ref_idle));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (in_bank == BANK_W'(b));
    sdram_bank_track #(
      .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
      .T_RP(T_RP), .T_WRP(T_WRP), .T_DAL(T_DAL)
    ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_act   (fire && cmd == CMD_ACT && hit),
      .do_wr    (fire && cmd == CMD_WR && hit),
      .do_close (fire && ((cmd == CMD_PRE && hit) || (cmd == CMD_PREA && bank_open[b]))),
      .row_in   (in_addr),
      .is_open  (bank_open[b]),
      .open_row (rows[b]),
      .col_ok   (col_ok[b]),
      .pre_ok   (pre_ok[b]),
      .rest_ok  (rest_ok[b]),
      .act_ok   (act_ok[b])
    );
  end

  assign cur_row = rows[in_bank];

  always_comb begin
    legal = 1'b0;
    bad   = 1'b0;
    unique case (cmd)
      CMD_NOP:  legal = 1'b1;
      CMD_ACT: begin
        legal = act_ok[in_bank] & rrd_idle & ref_idle;
        bad   = bank_open[in_bank];
      end
      CMD_RD, CMD_WR: begin
        legal = col_ok[in_bank];
        bad   = ~bank_open[in_bank];
      end
      CMD_PRE: begin
        legal = pre_ok[in_bank];
        bad   = ~bank_open[in_bank];
      end
      CMD_PREA: legal = &(~bank_open | pre_ok);
      CMD_REF: begin
        legal = (&rest_ok) & ref_idle;
        bad   = |bank_open;
      end
      default:  bad = 1'b1;
    endcase
  end

  assign in_ready = legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cmd  <= CMD_NOP;
      out_bank <= '0;
      out_addr <= '0;
      out_err  <= 1'b0;
    end else begin
      out_cmd  <= fire ? in_cmd  : CMD_NOP;
      out_bank <= fire ? in_bank : '0;
      out_addr <= fire ? in_addr : '0;
      out_err  <= in_valid & bad;
    end
  end
endmodule

// File: rtl/sdram_cmd_guard_chk.sv
module sdram_cmd_guard_chk
  import sdram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD = 2,
  parameter int T_RAS = 6,
  parameter int T_RC  = 10,
  parameter int T_RP  = 2,
  parameter int T_RRD = 2,
  parameter int T_WRP = 2,
  parameter int T_DAL = 5,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           out_cmd,
  input logic [BANK_W-1:0]    out_bank,
  input logic                 out_err,
  input logic [NUM_BANKS-1:0] bank_open
);
  // Clocks elapsed since the last forwarded command of each kind (saturating).
  logic [7:0] s_act [NUM_BANKS];
  logic [7:0] s_wr  [NUM_BANKS];
  logic [7:0] s_pre [NUM_BANKS];
  logic [7:0] s_any, s_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_any <= 8'hFF;
      s_ref <= 8'hFF;
      for (int b = 0; b < NUM_BANKS; b++) begin
        s_act[b] <= 8'hFF;
        s_wr[b]  <= 8'hFF;
        s_pre[b] <= 8'hFF;
      end
    end else begin
      s_any <= (out_cmd == CMD_ACT) ? 8'd1 : ((s_any == 8'hFF) ? s_any : s_any + 8'd1);
      s_ref <= (out_cmd == CMD_REF) ? 8'd1 : ((s_ref == 8'hFF) ? s_ref : s_ref + 8'd1);
      for (int b = 0; b < NUM_BANKS; b++) begin
        s_act[b] <= (out_cmd == CMD_ACT && out_bank == BANK_W'(b)) ? 8'd1 :
                    ((s_act[b] == 8'hFF) ? s_act[b] : s_act[b] + 8'd1);
        s_wr[b]  <= (out_cmd == CMD_WR && out_bank == BANK_W'(b)) ? 8'd1 :
                    ((s_wr[b] == 8'hFF) ? s_wr[b] : s_wr[b] + 8'd1);
        s_pre[b] <= (out_cmd == CMD_PRE && out_bank == BANK_W'(b)) ? 8'd1 :
                    ((s_pre[b] == 8'hFF) ? s_pre[b] : s_pre[b] + 8'd1);
      end
    end
  end

  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cmd == CMD_RD || out_cmd == CMD_WR) |-> (32'(s_act[out_bank]) >= T_RCD)); // R3
  AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cmd == CMD_PRE) |-> (32'(s_act[out_bank]) >= T_RAS && 32'(s_wr[out_bank]) >= T_WRP)); // R4
  AST_RRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cmd == CMD_ACT) |-> (32'(s_any) >= T_RRD)); // R5
  AST_RC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cmd == CMD_ACT) |-> (32'(s_act[out_bank]) >= T_RC)); // R6
  AST_DAL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cmd == CMD_ACT) |-> (32'(s_wr[out_bank]) >= T_DAL && 32'(s_pre[out_bank]) >= T_RP)); // R7
  AST_ERR_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_cmd == CMD_NOP)); // R9
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cmd == CMD_ACT) |-> bank_open[out_bank]); // R12
  AST_REF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cmd == CMD_REF) |-> (bank_open == '0 && 32'(s_ref) >= T_RC)); // R10
  AST_PREA_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cmd == CMD_PREA) |-> (bank_open == '0)); // R11
endmodule

bind sdram_cmd_guard sdram_cmd_guard_chk #(
  .NUM_BANKS(NUM_BANKS), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
  .T_RP(T_RP), .T_RRD(T_RRD), .T_WRP(T_WRP), .T_DAL(T_DAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_cmd(out_cmd), .out_bank(out_bank),
  .out_err(out_err), .bank_open(bank_open)
);

// File: tb/sdram_cmd_guard_bench.sv
module sdram_cmd_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 2, T_RAS = 6, T_RC = 10, T_RP = 2, T_RRD = 2, T_WRP = 2, T_DAL = 5;
  localparam logic [2:0] C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4,
                         C_PREA = 5, C_REF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [2:0] in_cmd = '0;
  logic [1:0] in_bank = '0;
  logic [11:0] in_addr = '0;
  logic [2:0] out_cmd;
  logic [1:0] out_bank;
  logic [11:0] out_addr;
  logic out_err;
  logic [3:0] bank_open;
  logic [11:0] cur_row;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_guard u_sdram_cmd_guard (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cmd(in_cmd), .in_bank(in_bank), .in_addr(in_addr),
    .out_cmd(out_cmd), .out_bank(out_bank), .out_addr(out_addr),
    .out_err(out_err), .bank_open(bank_open), .cur_row(cur_row)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // Timestamp model
  int cyc = 0;
  int t_act[4], t_wr[4], t_pre[4];
  int t_any = -1000, t_ref = -1000;
  bit m_open[4];
  logic [11:0] m_row[4];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic bit can_pre(input int b);
    return m_open[b] && (cyc - t_act[b] >= T_RAS) && (cyc - t_wr[b] >= T_WRP);
  endfunction

  function automatic bit m_legal(input logic [2:0] c, input int b);
    bit ok;
    case (c)
      C_NOP: return 1;
      C_ACT: return !m_open[b] && (cyc - t_act[b] >= T_RC) && (cyc - t_pre[b] >= T_RP) &&
                    (cyc - t_wr[b] >= T_DAL) && (cyc - t_any >= T_RRD) && (cyc - t_ref >= T_RC);
      C_RD, C_WR: return m_open[b] && (cyc - t_act[b] >= T_RCD);
      C_PRE: return can_pre(b);
      C_PREA: begin
        ok = 1;
        for (int i = 0; i < 4; i++) if (m_open[i] && !can_pre(i)) ok = 0;
        return ok;
      end
      C_REF: begin
        ok = (cyc - t_ref >= T_RC);
        for (int i = 0; i < 4; i++)
          if (m_open[i] || (cyc - t_pre[i] < T_RP) || (cyc - t_wr[i] < T_DAL)) ok = 0;
        return ok;
      end
      default: return 0;
    endcase
  endfunction

  function automatic bit m_bad(input logic [2:0] c, input int b);
    bit any_open;
    any_open = m_open[0] | m_open[1] | m_open[2] | m_open[3];
    case (c)
      C_ACT: return m_open[b];
      C_RD, C_WR, C_PRE: return !m_open[b];
      C_REF: return any_open;
      C_NOP, C_PREA: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      C_ACT: return "R6";
      C_RD, C_WR: return "R3";
      C_PRE: return "R4";
      C_PREA: return "R11";
      C_REF: return "R10";
      C_NOP: return "R2";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [3:0] m_mask();
    return {m_open[3], m_open[2], m_open[1], m_open[0]};
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic offer(input logic [2:0] c, input int b, input logic [11:0] a,
                       input bit v, input string tag);
    bit er, ee;
    in_valid = v; in_cmd = c; in_bank = 2'(b); in_addr = a;
    #1;
    er = m_legal(c, b);
    ee = v && m_bad(c, b);
    if (v) chk(in_ready === er, tag, "in_ready", int'(in_ready), int'(er));
    if (v && m_open[b]) chk(cur_row === m_row[b], "R12", "cur_row", int'(cur_row), int'(m_row[b]));
    @(posedge clk);
    if (v && er) begin
      case (c)
        C_ACT: begin m_open[b] = 1; m_row[b] = a; t_act[b] = cyc; t_any = cyc; end
        C_WR:  t_wr[b] = cyc;
        C_PRE: begin m_open[b] = 0; t_pre[b] = cyc; end
        C_PREA: for (int i = 0; i < 4; i++) if (m_open[i]) begin m_open[i] = 0; t_pre[i] = cyc; end
        C_REF: t_ref = cyc;
        default: ;
      endcase
    end
    cyc++;
    @(negedge clk);
    chk(out_cmd === ((v && er) ? c : C_NOP), "R2", "out_cmd", int'(out_cmd), int'((v && er) ? c : C_NOP));
    if (v && er) begin
      chk(out_bank === 2'(b), "R2", "out_bank", int'(out_bank), b);
      chk(out_addr === a, "R2", "out_addr", int'(out_addr), int'(a));
    end
    chk(out_err === ee, "R9", "out_err", int'(out_err), int'(ee));
    chk(bank_open === m_mask(), "R12", "bank_open", int'(bank_open), int'(m_mask()));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      t_act[i] = -1000; t_wr[i] = -1000; t_pre[i] = -1000; m_open[i] = 0; m_row[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(out_cmd === C_NOP, "R1", "out_cmd in reset", int'(out_cmd), 0);
    chk(out_err === 1'b0, "R1", "out_err in reset", int'(out_err), 0);
    chk(bank_open === 4'd0, "R1", "bank_open in reset", int'(bank_open), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_cmd === C_NOP && bank_open === 4'd0, "R1", "state after reset", int'(bank_open), 0);

    // Directed corners
    offer(C_ACT, 0, 12'h123, 1, "R6");   // accepted
    offer(C_ACT, 1, 12'h0AA, 1, "R5");   // one clock later: blocked by bank-to-bank gap
    offer(C_RD,  0, 12'h010, 1, "R3");   // exactly T_RCD later: ready
    offer(C_RD,  0, 12'h011, 1, "R8");   // back-to-back column
    offer(C_WR,  0, 12'h012, 1, "R8");
    offer(C_PRE, 0, 12'h000, 1, "R4");   // T_RAS not reached
    offer(C_PRE, 0, 12'h000, 1, "R4");   // T_RAS and write recovery met
    offer(C_ACT, 0, 12'h222, 1, "R7");   // inside T_RP
    offer(C_REF, 0, 12'h000, 1, "R10");  // inside write-to-refresh gap
    offer(C_REF, 0, 12'h000, 1, "R10");  // now legal
    offer(C_ACT, 2, 12'h333, 1, "R10");  // blocked after refresh
    offer(C_RD,  1, 12'h000, 1, "R9");   // closed bank -> error
    offer(C_RSV_CODE(), 3, 12'h000, 1, "R9");
    for (int k = 0; k < 10; k++) offer(C_NOP, 0, 12'h000, 1, "R2");
    offer(C_ACT, 2, 12'h333, 1, "R6");
    offer(C_ACT, 2, 12'h334, 1, "R9");   // already open -> error
    offer(C_ACT, 3, 12'h444, 1, "R5");
    offer(C_PREA, 0, 12'h000, 1, "R11"); // too early
    for (int k = 0; k < 6; k++) offer(C_NOP, 0, 12'h000, 0, "R2");
    offer(C_PREA, 0, 12'h000, 1, "R11");
    offer(C_ACT, 2, 12'h555, 1, "R7");   // inside T_RP after close-all

    // Seeded random traffic
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] c;
      c = 3'($urandom_range(0, 7));
      offer(c, int'($urandom_range(0, 3)), 12'($urandom), $urandom_range(0, 9) != 0, tag_of(c));
    end

    in_valid = 1'b0;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [2:0] C_RSV_CODE();
    return 3'd7;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule